// File: doc/BRIEF.md
# Static Wear-Leveling Block Mapper

This block sits between a host that thinks in logical blocks and a small flash array made of physical blocks. A register table turns each logical block number into a physical block number, so from the host's side the data always stays at the same address. Each physical block has a saturating erase counter. A write sends the logical block to the least-worn physical block, and this choice covers every physical block, spares included, and not only the free ones. When the chosen block still holds cold data for another logical block, that data is first moved onto the most-worn free block. Only then is the chosen block reused.

The host issues reads and writes with a valid/ready handshake. A read returns the current mapping on the next cycle. A write runs a short command sequence through a flash handshake: `fl_req` is held with its fields until the memory model pulses `fl_ack`. The sequence ends with a response carrying the new physical block. The states are `ST_IDLE`, `ST_COPY`, `ST_ERASE_TGT` and `ST_ERASE_OLD`.

The transitions are:
- `ST_IDLE`→`ST_COPY` on a write whose target is occupied (relocate).
- `ST_IDLE`→`ST_ERASE_OLD` on a write whose target is free (direct).
- `ST_COPY`→`ST_ERASE_TGT` on ack (copy done).
- `ST_ERASE_TGT`→`ST_ERASE_OLD` on ack (target cleaned).
- `ST_ERASE_OLD`→`ST_IDLE` on ack (retire, respond).

Top module: `wl_block_mapper`

## Requirements
- R1: After reset, logical block n maps to physical block n. The spare physical blocks (index N_LOG and above) are free, and every erase counter is zero.
- R2: A read accepted on one clock edge gives `resp_valid` high with `resp_pba` equal to the current mapping after the next edge. A read issues no flash command and changes no counter, so later write choices are unchanged.
- R3: A write to logical block L targets the physical block with the lowest erase count among all blocks except L's current one, with the lowest index winning ties. The write response returns that block, and L maps to it afterwards.
- R4: If the target is free, the only flash command is an erase (`fl_op`=0) of L's previous block.
- R5: If the target holds another logical block M, the commands are, in order:
  - a copy (`fl_op`=1, `fl_src`=target, `fl_dst`=destination), where the destination is the free block with the highest erase count and the lowest index wins ties;
  - an erase of the target;
  - an erase of L's previous block.

  After this, M maps to the destination.
- R6: Each acknowledged erase adds one to the erased block's counter. The counter saturates at 2^CNT_W−1. `fl_dst` is only meaningful for a copy.
- R7: While a write sequence runs, `busy` is 1 and `req_ready` is 0. A request held during that time is accepted on the first edge after the sequence ends.
- R8: A flash command stays asserted with stable op, source and destination until `fl_ack`.
- R9: Whenever the block is idle, the mapping is one-to-one, and exactly N_LOG physical blocks are in use.
- R10: Spare physical blocks take part in the rotation and do become write targets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Request accepted on this edge when high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_lba | input | $clog2(N_LOG) | Logical block number |
| resp_valid | output | 1 | One-cycle response pulse |
| resp_pba | output | $clog2(N_PHY) | Physical block returned |
| busy | output | 1 | Write sequence in progress |
| fl_req | output | 1 | Flash command pending |
| fl_op | output | 1 | 0 = erase fl_src, 1 = copy fl_src to fl_dst |
| fl_src | output | $clog2(N_PHY) | Source or erased block |
| fl_dst | output | $clog2(N_PHY) | Copy destination |
| fl_ack | input | 1 | Flash model completes the pending command |

## Verification
Counter saturation is the hardest state to reach. Counters are not visible at the ports, and wear is spread over every block, so one block can only saturate after the whole array has been worn. The bench builds the design with 4-bit counters and runs several hundred pseudo-random writes with varying acknowledge delays. After saturation every counter is equal, so the lowest-index tie rules decide each choice. Every flash command and response is compared against a reference model of the requirements, so a counter that wraps, skips or moves on a read shows up as a wrong target.

// File: rtl/wl_pkg.sv
package wl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_COPY      = 2'd1,
        ST_ERASE_TGT = 2'd2,
        ST_ERASE_OLD = 2'd3
    } wl_state_e;

    typedef enum logic {
        OP_ERASE = 1'b0,
        OP_COPY  = 1'b1
    } wl_op_e;

endpackage

// File: rtl/wl_argsel.sv
module wl_argsel #(
    parameter int N        = 10,
    parameter int CW       = 16,
    parameter bit PICK_MAX = 1'b0,
    localparam int IW      = $clog2(N)
) (
    input  logic [N-1:0][CW-1:0] cnt,
    input  logic [N-1:0]         en,
    output logic [IW-1:0]        idx,
    output logic                 found
);

    logic [N-1:0] beats;
    logic [CW-1:0] best_cnt;

    // candidate i displaces the running best only when strictly better,
    // so the lowest index wins any tie
    always_comb begin
        idx      = '0;
        found    = 1'b0;
        best_cnt = '0;
        beats    = '0;
        for (int i = 0; i < N; i++) begin
            if (PICK_MAX) beats[i] = cnt[i] > best_cnt;
            else          beats[i] = cnt[i] < best_cnt;
            if (en[i] && (!found || beats[i])) begin
                found    = 1'b1;
                best_cnt = cnt[i];
                idx      = IW'(i);
            end
        end
    end

endmodule

// File: rtl/wl_wear_bank.sv
module wl_wear_bank #(
    parameter int N   = 10,
    parameter int CW  = 16,
    localparam int IW = $clog2(N)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 inc_en,
    input  logic [IW-1:0]        inc_idx,
    output logic [N-1:0][CW-1:0] cnt
);

    localparam logic [CW-1:0] CMAX = '1;

    for (genvar g = 0; g < N; g++) begin : g_ctr
        logic hit;
        assign hit = inc_en && (inc_idx == IW'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                  cnt[g] <= '0;
            else if (hit && cnt[g] != CMAX) cnt[g] <= cnt[g] + 1'b1;
        end

        // R6
        cnt_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
            cnt[g] >= $past(cnt[g]));

        // R6
        cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt[g] == CMAX) |=> (cnt[g] == CMAX));
    end

endmodule

// File: rtl/wl_block_mapper.sv
module wl_block_mapper #(
    parameter int N_LOG = 8,
    parameter int N_PHY = 10,
    parameter int CNT_W = 16,
    localparam int LW   = $clog2(N_LOG),
    localparam int PW   = $clog2(N_PHY)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic [LW-1:0] req_lba,
    output logic          resp_valid,
    output logic [PW-1:0] resp_pba,
    output logic          busy,
    output logic          fl_req,
    output logic          fl_op,
    output logic [PW-1:0] fl_src,
    output logic [PW-1:0] fl_dst,
    input  logic          fl_ack
);
    import wl_pkg::*;

    wl_state_e state_q, state_d;
    wl_op_e    op_c;

    logic [PW-1:0] map_q [N_LOG];
    logic [N_PHY-1:0] used_q;
    logic [N_PHY-1:0][CNT_W-1:0] cnt;

    logic [LW-1:0] lba_q, own_q, own_c;
    logic [PW-1:0] old_q, tgt_q, dst_q, old_c, tgt_c, dst_c;
    logic [N_PHY-1:0] not_old;
    logic min_found, max_found, relocate_c, accept, done, inc_en;

    assign accept = req_valid && (state_q == ST_IDLE);
    assign done   = fl_req && fl_ack;
    assign old_c  = map_q[req_lba];

    always_comb begin
        for (int p = 0; p < N_PHY; p++) not_old[p] = (old_c != PW'(p));
    end

    wl_argsel #(.N(N_PHY), .CW(CNT_W), .PICK_MAX(1'b0)) i_least (
        .cnt(cnt), .en(not_old), .idx(tgt_c), .found(min_found));

    wl_argsel #(.N(N_PHY), .CW(CNT_W), .PICK_MAX(1'b1)) i_most (
        .cnt(cnt), .en(~used_q), .idx(dst_c), .found(max_found));

    always_comb begin
        own_c = '0;
        for (int l = 0; l < N_LOG; l++)
            if (map_q[l] == tgt_c) own_c = LW'(l);
    end

    assign relocate_c = used_q[tgt_c];
    assign inc_en     = done && (op_c == OP_ERASE);

    wl_wear_bank #(.N(N_PHY), .CW(CNT_W)) i_wear (
        .clk(clk), .rst_n(rst_n), .inc_en(inc_en), .inc_idx(fl_src), .cnt(cnt));

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (accept && req_write)
                              state_d = relocate_c ? ST_COPY : ST_ERASE_OLD;
            ST_COPY:      if (done) state_d = ST_ERASE_TGT;
            ST_ERASE_TGT: if (done) state_d = ST_ERASE_OLD;
            ST_ERASE_OLD: if (done) state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // table, bookkeeping of the running write, response
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int l = 0; l < N_LOG; l++) map_q[l] <= PW'(l);
            for (int p = 0; p < N_PHY; p++) used_q[p] <= (p < N_LOG);
            lba_q <= '0; own_q <= '0;
            old_q <= '0; tgt_q <= '0; dst_q <= '0;
            resp_valid <= 1'b0;
            resp_pba   <= '0;
        end else begin
            resp_valid <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (accept) begin
                    if (req_write) begin
                        lba_q <= req_lba;
                        old_q <= old_c;
                        tgt_q <= tgt_c;
                        dst_q <= dst_c;
                        own_q <= own_c;
                        if (!relocate_c) begin
                            map_q[req_lba] <= tgt_c;
                            used_q[tgt_c]  <= 1'b1;
                        end
                    end else begin
                        resp_valid <= 1'b1;
                        resp_pba   <= old_c;
                    end
                end
                ST_COPY: if (done) begin
                    map_q[own_q]  <= dst_q;
                    used_q[dst_q] <= 1'b1;
                end
                ST_ERASE_TGT: if (done) map_q[lba_q] <= tgt_q;
                ST_ERASE_OLD: if (done) begin
                    used_q[old_q] <= 1'b0;
                    resp_valid    <= 1'b1;
                    resp_pba      <= tgt_q;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        fl_req = 1'b1;
        op_c   = OP_ERASE;
        fl_src = old_q;
        fl_dst = old_q;
        unique case (state_q)
            ST_IDLE:      fl_req = 1'b0;
            ST_COPY:      begin op_c = OP_COPY; fl_src = tgt_q; fl_dst = dst_q; end
            ST_ERASE_TGT: begin fl_src = tgt_q; fl_dst = tgt_q; end
            ST_ERASE_OLD: ;
        endcase
        fl_op     = op_c;
        busy      = (state_q != ST_IDLE);
        req_ready = (state_q == ST_IDLE);
    end

    // R2
    read_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !req_write) |=> (resp_valid && !fl_req));

    // R7
    wr_starts_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_write) |=> (busy && fl_req && !resp_valid));

    // R8
    cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_req && !fl_ack) |=> (fl_req && $stable(fl_op) && $stable(fl_src) && $stable(fl_dst)));

    // R9
    one_to_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> ($countones(used_q) == N_LOG));

    // R3
    tgt_not_old_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ERASE_OLD) |-> (tgt_q != old_q));

    // R10
    spare_avail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_write) |-> (min_found && max_found));

endmodule

// File: tb/test_wl_block_mapper.sv
module test_wl_block_mapper;

    localparam int NL   = 8;
    localparam int NP   = 10;
    localparam int CW   = 4;
    localparam int CMAX = (1 << CW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0, fl_ack = 1'b0;
    logic [2:0] req_lba = '0;
    logic req_ready, resp_valid, busy, fl_req, fl_op;
    logic [3:0] resp_pba, fl_src, fl_dst;

    always #2 clk = ~clk;

    wl_block_mapper #(.N_LOG(NL), .N_PHY(NP), .CNT_W(CW)) i_wl_block_mapper (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_lba(req_lba), .resp_valid(resp_valid),
        .resp_pba(resp_pba), .busy(busy), .fl_req(fl_req), .fl_op(fl_op),
        .fl_src(fl_src), .fl_dst(fl_dst), .fl_ack(fl_ack));

    int checks = 0, errors = 0;
    int m_map [NL];
    int m_used [NP];
    int m_cnt [NP];
    int n_reloc = 0, n_direct = 0, seen_spare = 0;
    int lfsr = 16'hACE1;

    function automatic int rnd();
        lfsr = ((lfsr >> 1) ^ ((lfsr & 1) ? 16'hB400 : 0)) & 16'hFFFF;
        return lfsr;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic sat_inc(input int p);
        if (m_cnt[p] < CMAX) m_cnt[p]++;
    endtask

    task automatic do_read(input int lba);
        req_valid = 1'b1; req_write = 1'b0; req_lba = 3'(lba);
        @(negedge clk);
        req_valid = 1'b0;
        chk(resp_valid == 1'b1, "R2 read resp_valid", int'(resp_valid), 1);
        chk(int'(resp_pba) == m_map[lba], "R2 read mapping", int'(resp_pba), m_map[lba]);
        chk(fl_req == 1'b0 && busy == 1'b0, "R2 read no flash command", int'(fl_req), 0);
    endtask

    task automatic do_write(input int lba, input bit stall, input int rl);
        int old, tgt, dst, own, n;
        int eo [3];
        int es [3];
        int ed [3];
        old = m_map[lba];
        tgt = -1;
        for (int p = 0; p < NP; p++)
            if (p != old && (tgt < 0 || m_cnt[p] < m_cnt[tgt])) tgt = p;
        if (m_used[tgt] != 0) begin
            own = 0;
            for (int l = 0; l < NL; l++) if (m_map[l] == tgt) own = l;
            dst = -1;
            for (int p = 0; p < NP; p++)
                if (m_used[p] == 0 && (dst < 0 || m_cnt[p] > m_cnt[dst])) dst = p;
            eo[0] = 1; es[0] = tgt; ed[0] = dst;
            eo[1] = 0; es[1] = tgt; ed[1] = 0;
            eo[2] = 0; es[2] = old; ed[2] = 0;
            n = 3; n_reloc++;
            m_map[own] = dst; m_used[dst] = 1; sat_inc(tgt); m_map[lba] = tgt;
        end else begin
            eo[0] = 0; es[0] = old; ed[0] = 0;
            n = 1; n_direct++;
            m_map[lba] = tgt; m_used[tgt] = 1;
        end
        sat_inc(old); m_used[old] = 0;
        if (tgt >= NL) seen_spare = 1;

        req_valid = 1'b1; req_write = 1'b1; req_lba = 3'(lba);
        @(negedge clk);
        if (stall) begin
            req_write = 1'b0; req_lba = 3'(rl);
        end else req_valid = 1'b0;
        for (int k = 0; k < n; k++) begin
            int w, d;
            w = 0;
            while (!fl_req && w < 50) begin @(negedge clk); w++; end
            chk(fl_req == 1'b1, "R8 command raised", int'(fl_req), 1);
            chk(int'(fl_op) == eo[k], (n == 3) ? "R5 command op" : "R4 command op", int'(fl_op), eo[k]);
            chk(int'(fl_src) == es[k], (n == 3) ? "R5 command source" : "R4 command source", int'(fl_src), es[k]);
            if (eo[k] == 1) chk(int'(fl_dst) == ed[k], "R5 copy destination", int'(fl_dst), ed[k]);
            chk(busy == 1'b1 && req_ready == 1'b0, "R7 busy during sequence", int'(busy), 1);
            d = rnd() % 3;
            for (int j = 0; j < d; j++) begin
                @(negedge clk);
                chk(fl_req == 1'b1 && int'(fl_src) == es[k], "R8 command held", int'(fl_src), es[k]);
                if (stall) chk(resp_valid == 1'b0, "R7 stalled request not served", int'(resp_valid), 0);
            end
            fl_ack = 1'b1;
            @(negedge clk);
            fl_ack = 1'b0;
        end
        chk(resp_valid == 1'b1, "R3 write response", int'(resp_valid), 1);
        chk(int'(resp_pba) == tgt, "R3 write target", int'(resp_pba), tgt);
        chk(busy == 1'b0 && fl_req == 1'b0, "R7 idle after sequence", int'(busy), 0);
        if (stall) begin
            @(negedge clk);
            req_valid = 1'b0;
            chk(resp_valid == 1'b1 && int'(resp_pba) == m_map[rl],
                "R7 held read served after sequence", int'(resp_pba), m_map[rl]);
        end
    endtask

    task automatic t_reset();
        for (int l = 0; l < NL; l++) m_map[l] = l;
        for (int p = 0; p < NP; p++) begin m_used[p] = (p < NL); m_cnt[p] = 0; end
        chk(busy == 1'b0 && req_ready == 1'b1 && fl_req == 1'b0, "R1 idle after reset", int'(busy), 0);
        for (int l = 0; l < NL; l++) begin
            do_read(l);
            chk(int'(resp_pba) == l, "R1 identity mapping", int'(resp_pba), l);
        end
    endtask

    task automatic t_first_write();
        // all counters zero: target is block 1 (lowest index != 0), which holds
        // logical 1; destination is spare 8 (tie among free, lowest index)
        do_write(0, 1'b0, 0);
        do_read(0);
        chk(int'(resp_pba) == 1, "R3 tie picks lowest index", int'(resp_pba), 1);
        do_read(1);
        chk(int'(resp_pba) == 8, "R5 relocated data on most-worn free", int'(resp_pba), 8);
    endtask

    task automatic t_stall();
        do_write(5, 1'b1, 1);
        do_write(2, 1'b1, 5);
    endtask

    task automatic t_soak();
        for (int i = 0; i < 300; i++) begin
            int l;
            l = rnd() % NL;
            do_write(l, (i % 11) == 4, (l + 3) % NL);
            if ((i % 9) == 0) do_read(rnd() % NL);
        end
    endtask

    task automatic t_final();
        int seen [NP];
        int mx;
        for (int p = 0; p < NP; p++) seen[p] = 0;
        for (int l = 0; l < NL; l++) begin
            do_read(l);
            seen[int'(resp_pba)]++;
        end
        for (int p = 0; p < NP; p++)
            chk(seen[p] <= 1, "R9 no two logical blocks share a physical block", seen[p], 1);
        chk(n_direct > 0, "R4 direct writes occurred", n_direct, 1);
        chk(n_reloc > 0, "R5 relocations occurred", n_reloc, 1);
        chk(seen_spare == 1, "R10 spare block became a target", seen_spare, 1);
        mx = 0;
        for (int p = 0; p < NP; p++) if (m_cnt[p] > mx) mx = m_cnt[p];
        chk(mx == CMAX, "R6 counters driven into saturation", mx, CMAX);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_first_write();
        t_stall();
        t_soak();
        t_final();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule